// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one multi-register load or store instruction, already decoded, and breaks it into simple micro-ops. The instruction arrives as a register-select mask, a base register index and a set of mode flags: increment or decrement, pre- or post-indexed, base writeback, load or store, the status-bit option, and whether the program counter is in the mask. The block then issues one micro-op per cycle on a valid/ready output port. Execution and memory access take place further down the pipeline.

Every sequence begins by copying the base register into a scratch register. Each transfer micro-op then computes its address from that scratch copy, so a load that overwrites the base cannot disturb the addresses of later transfers. Registers are transferred in ascending index order. The block picks the starting offset from the addressing mode and steps the offset by 4 after each transfer. When writeback is requested, a final micro-op adds or subtracts four times the register count to or from the base.

The controller has four states. IDLE waits for an instruction. COPY issues the base copy. XFER issues one transfer per set mask bit. WBACK issues the base update. The transitions are:
- IDLE→COPY when an instruction is accepted.
- COPY→XFER when the mask is not empty.
- COPY→WBACK or COPY→IDLE when the mask is empty, depending on writeback.
- XFER→WBACK or XFER→IDLE when the last mask bit is handed off, depending on writeback.
- WBACK→IDLE when the update is handed off.

Each of these moves out of COPY, XFER or WBACK happens only on an output handshake.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset the block is in IDLE with `in_ready` high and `out_valid` low.
- R2: An instruction is accepted only in IDLE, when `in_valid` and `in_ready` are both high. While a sequence is outstanding, `in_ready` is low and all instruction inputs are ignored.
- R3: The cycle after acceptance, the first micro-op appears. It has op code 0 (copy), destination equal to the scratch index NREGS (16), source equal to the base, immediate 0, up 1 and user 0.
- R4: Transfer micro-ops follow, one for each set mask bit, in ascending register index. Each has source equal to the scratch index. A store uses op code 3. A load uses op code 1, except in the case given by R6.
- R5: The offset of the first transfer is 0 in increment mode and count*4-4 in decrement mode, plus 4 when pre-indexed. After each transfer the offset moves by 4, up in increment mode and down in decrement mode. Every transfer's up bit equals the increment flag, and the immediate is 7 bits wide.
- R6: For a load with the status-bit option set and the program counter flagged in the list, the transfer of register 15 uses op code 2 (load with status restore).
- R7: When the status-bit option is set and the program counter is not flagged, every transfer, load or store, has user 1. All other micro-ops have user 0.
- R8: With writeback, one final micro-op follows. It has op code 4 (add) in increment mode or 5 (subtract) in decrement mode, destination and source equal to the base, and immediate count*4.
- R9: Exactly count+1 micro-ops are issued, plus one more with writeback, where count is the number of set mask bits. Only the final one has `out_last` high. The block is back in IDLE the cycle after the final handshake.
- R10: An empty mask issues only the copy micro-op, followed by the writeback micro-op when writeback is requested.
- R11: While `out_valid` is high and `out_ready` is low, every output field stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block is idle and takes an instruction |
| in_list | input | NREGS | Register-select mask, bit i selects register i |
| in_base | input | IDX_W | Base register index |
| in_up | input | 1 | 1 = increment, 0 = decrement |
| in_pre | input | 1 | 1 = pre-indexed |
| in_wb | input | 1 | Write the updated base back |
| in_load | input | 1 | 1 = load, 0 = store |
| in_psr | input | 1 | Status-bit option |
| in_pc_listed | input | 1 | Program counter is in the mask |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_op | output | 3 | 0 copy, 1 load, 2 load with status restore, 3 store, 4 add, 5 subtract |
| out_dst | output | IDX_W | Destination register |
| out_user | output | 1 | Force user-bank register access |
| out_src | output | IDX_W | Source (address) register |
| out_imm | output | OFF_W | Immediate offset |
| out_up | output | 1 | Sign of the immediate, 1 = add |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench builds the block with its default of 16 registers. This makes register 15 the program counter, 16 the scratch index, and 7-bit immediates. A full mask in decrement, pre-indexed mode therefore reaches the largest offset, 64, which is also the largest writeback immediate. Random masks, modes and stalls on `out_ready` are checked against a reference sequence computed by the bench. Directed cases cover empty masks, the full mask, exception-return loads and user-forced stores.

// File: rtl/lsm_uop_pkg.sv
package lsm_uop_pkg;

    typedef enum logic [2:0] {
        UOP_COPY     = 3'd0,
        UOP_LOAD     = 3'd1,
        UOP_LOAD_RET = 3'd2,
        UOP_STORE    = 3'd3,
        UOP_ADDI     = 3'd4,
        UOP_SUBI     = 3'd5
    } uop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_XFER  = 2'd2,
        ST_WBACK = 2'd3
    } seq_state_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_uop_fmt.sv
module lsm_uop_fmt
    import lsm_uop_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int IDX_W = $clog2(NREGS) + 1,
    parameter int RI_W  = $clog2(NREGS),
    parameter int OFF_W = $clog2(NREGS * 4 + 1)
) (
    input  seq_state_e       st,
    input  logic [IDX_W-1:0] base,
    input  logic [RI_W-1:0]  cur_idx,
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] total,
    input  logic             up,
    input  logic             wb,
    input  logic             ld,
    input  logic             psr,
    input  logic             pcf,
    input  logic             cnt_zero,
    input  logic             rest_one,
    output logic             valid,
    output uop_op_e          op,
    output logic [IDX_W-1:0] dst,
    output logic             user,
    output logic [IDX_W-1:0] src,
    output logic [OFF_W-1:0] imm,
    output logic             sign_up,
    output logic             last
);
    localparam int TEMP_REG = NREGS;
    localparam int PC_IDX   = NREGS - 1;

    always_comb begin
        valid   = 1'b0;
        op      = UOP_COPY;
        dst     = '0;
        user    = 1'b0;
        src     = '0;
        imm     = '0;
        sign_up = 1'b0;
        last    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                valid = 1'b0;
            end
            ST_COPY: begin
                valid   = 1'b1;
                op      = UOP_COPY;
                dst     = IDX_W'(TEMP_REG);
                src     = base;
                sign_up = 1'b1;
                last    = cnt_zero && !wb;
            end
            ST_XFER: begin
                valid = 1'b1;
                if (ld) begin
                    op = (cur_idx == RI_W'(PC_IDX) && psr && pcf) ? UOP_LOAD_RET : UOP_LOAD;
                end else begin
                    op = UOP_STORE;
                end
                dst     = IDX_W'(cur_idx);
                user    = psr && !pcf;
                src     = IDX_W'(TEMP_REG);
                imm     = off;
                sign_up = up;
                last    = rest_one && !wb;
            end
            ST_WBACK: begin
                valid   = 1'b1;
                op      = up ? UOP_ADDI : UOP_SUBI;
                dst     = base;
                src     = base;
                imm     = total;
                sign_up = up;
                last    = 1'b1;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_uop_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS) + 1,
    localparam int RI_W  = $clog2(NREGS),
    localparam int CNT_W = $clog2(NREGS + 1),
    localparam int OFF_W = $clog2(NREGS * 4 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NREGS-1:0] in_list,
    input  logic [IDX_W-1:0] in_base,
    input  logic             in_up,
    input  logic             in_pre,
    input  logic             in_wb,
    input  logic             in_load,
    input  logic             in_psr,
    input  logic             in_pc_listed,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_op,
    output logic [IDX_W-1:0] out_dst,
    output logic             out_user,
    output logic [IDX_W-1:0] out_src,
    output logic [OFF_W-1:0] out_imm,
    output logic             out_up,
    output logic             out_last
);
    localparam int TEMP_REG = NREGS;

    seq_state_e       state, nxt;
    logic [NREGS-1:0] list_q;
    logic [IDX_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OFF_W-1:0] off_q;
    logic             up_q, wb_q, ld_q, psr_q, pcf_q;

    logic [CNT_W-1:0] in_cnt;
    logic [OFF_W-1:0] in_x4, start_off, total;
    logic [RI_W-1:0]  cur_idx;
    logic             found;
    logic             cnt_zero, rest_one, fire, accept;
    uop_op_e          op_w;

    lsm_popcnt #(.W(NREGS), .CW(CNT_W)) u_cnt (
        .vec (in_list),
        .cnt (in_cnt)
    );

    lsm_lowbit #(.W(NREGS), .IW(RI_W)) u_low (
        .vec   (list_q),
        .idx   (cur_idx),
        .found (found)
    );

    assign in_x4     = OFF_W'(in_cnt) << 2;
    assign start_off = (in_up ? '0 : (in_x4 - OFF_W'(4))) + (in_pre ? OFF_W'(4) : '0);
    assign total     = OFF_W'(cnt_q) << 2;
    assign cnt_zero  = (cnt_q == '0);
    assign rest_one  = ((list_q & (list_q - NREGS'(1))) == '0);
    assign in_ready  = (state == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign fire      = out_valid && out_ready;

    lsm_uop_fmt #(.NREGS(NREGS), .IDX_W(IDX_W), .RI_W(RI_W), .OFF_W(OFF_W)) u_fmt (
        .st       (state),
        .base     (base_q),
        .cur_idx  (cur_idx),
        .off      (off_q),
        .total    (total),
        .up       (up_q),
        .wb       (wb_q),
        .ld       (ld_q),
        .psr      (psr_q),
        .pcf      (pcf_q),
        .cnt_zero (cnt_zero),
        .rest_one (rest_one),
        .valid    (out_valid),
        .op       (op_w),
        .dst      (out_dst),
        .user     (out_user),
        .src      (out_src),
        .imm      (out_imm),
        .sign_up  (out_up),
        .last     (out_last)
    );
    assign out_op = op_w;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) nxt = ST_COPY;
            ST_COPY:  if (fire) nxt = cnt_zero ? (wb_q ? ST_WBACK : ST_IDLE) : ST_XFER;
            ST_XFER:  if (fire && rest_one) nxt = wb_q ? ST_WBACK : ST_IDLE;
            ST_WBACK: if (fire) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_q <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            off_q  <= '0;
            up_q   <= 1'b0;
            wb_q   <= 1'b0;
            ld_q   <= 1'b0;
            psr_q  <= 1'b0;
            pcf_q  <= 1'b0;
        end else if (accept) begin
            list_q <= in_list;
            base_q <= in_base;
            cnt_q  <= in_cnt;
            off_q  <= start_off;
            up_q   <= in_up;
            wb_q   <= in_wb;
            ld_q   <= in_load;
            psr_q  <= in_psr;
            pcf_q  <= in_pc_listed;
        end else if (state == ST_XFER && fire) begin
            list_q <= list_q & ~({{(NREGS-1){1'b0}}, 1'b1} << cur_idx);
            off_q  <= up_q ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> in_ready); // R1
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !out_valid); // R2
    AST_ACCEPT_COPY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> (out_valid && out_op == 3'(UOP_COPY))); // R3
    AST_XFER_FROM_TEMP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && (out_op == 3'(UOP_LOAD) || out_op == 3'(UOP_LOAD_RET) || out_op == 3'(UOP_STORE))) |-> out_src == IDX_W'(TEMP_REG)); // R4
    AST_XFER_HAS_REG: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_XFER) |-> found); // R4
    AST_USER_XFER_ONLY: assert property (@(posedge clk) disable iff (!rst_n) out_user |-> (out_valid && out_src == IDX_W'(TEMP_REG))); // R7
    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && out_last) |=> in_ready); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_dst) && $stable(out_imm) && $stable(out_user) && $stable(out_last))); // R11
endmodule

// File: tb/lsm_uop_seq_test.sv
`timescale 1ns/1ps
module lsm_uop_seq_test;
    localparam int NR   = 16;
    localparam int TEMP = 16;
    localparam int PC   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_list = '0;
    logic [4:0]  in_base = '0;
    logic        in_up = 1'b0, in_pre = 1'b0, in_wb = 1'b0, in_load = 1'b0, in_psr = 1'b0, in_pc_listed = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_op;
    logic [4:0]  out_dst, out_src;
    logic        out_user, out_up, out_last;
    logic [6:0]  out_imm;

    int total = 0;
    int bad   = 0;

    logic [22:0] exp_u [0:NR+1];
    string       exp_t [0:NR+1];
    int          exp_len;

    lsm_uop_seq #(.NREGS(NR)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_list(in_list), .in_base(in_base), .in_up(in_up), .in_pre(in_pre),
        .in_wb(in_wb), .in_load(in_load), .in_psr(in_psr), .in_pc_listed(in_pc_listed),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_dst(out_dst),
        .out_user(out_user), .out_src(out_src), .out_imm(out_imm), .out_up(out_up),
        .out_last(out_last)
    );

    always #10 clk = ~clk;

    function automatic logic [22:0] pack(input logic [2:0] op, input logic [4:0] dst, input logic user,
                                         input logic [4:0] src, input logic [6:0] imm, input logic up,
                                         input logic last);
        return {op, dst, user, src, imm, up, last};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [22:0] act, input logic [22:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic build_exp(input logic [15:0] lst, input logic [4:0] base, input logic up, input logic pre,
                             input logic wb, input logic ld, input logic psr, input logic pcf);
        int cnt = 0;
        int off;
        int k = 0;
        logic [2:0] op;
        for (int r = 0; r < NR; r++) cnt += int'(lst[r]);
        off = up ? 0 : cnt * 4 - 4;
        if (pre) off += 4;
        exp_u[0] = pack(3'd0, 5'(TEMP), 1'b0, base, 7'd0, 1'b1, (cnt == 0) && !wb);
        exp_t[0] = (cnt == 0) ? "R10" : "R3";
        for (int r = 0; r < NR; r++) begin
            if (lst[r]) begin
                k++;
                if (ld) op = (r == PC && psr && pcf) ? 3'd2 : 3'd1;
                else    op = 3'd3;
                exp_u[k] = pack(op, 5'(r), psr && !pcf, 5'(TEMP), 7'(off), up, (k == cnt) && !wb);
                exp_t[k] = (op == 3'd2) ? "R6" : ((psr && !pcf) ? "R7" : (up ? "R4" : "R5"));
                off = up ? off + 4 : off - 4;
            end
        end
        exp_len = cnt + 1;
        if (wb) begin
            exp_u[exp_len] = pack(up ? 3'd4 : 3'd5, base, 1'b0, base, 7'(cnt * 4), up, 1'b1);
            exp_t[exp_len] = (cnt == 0) ? "R10" : "R8";
            exp_len++;
        end
    endtask

    task automatic run(input logic [15:0] lst, input logic [4:0] base, input logic up, input logic pre,
                       input logic wb, input logic ld, input logic psr, input logic pcf, input bit junk);
        int idx = 0;
        int guard = 0;
        bit stalled = 0;
        logic [22:0] act, prev;
        prev = '0;
        build_exp(lst, base, up, pre, wb, ld, psr, pcf);
        @(negedge clk);
        in_list = lst; in_base = base; in_up = up; in_pre = pre; in_wb = wb;
        in_load = ld; in_psr = psr; in_pc_listed = pcf; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = junk;
        in_list = 16'($urandom); in_base = 5'($urandom % 16); in_up = ~up; in_wb = ~wb; in_load = ~ld;
        while (idx < exp_len && guard < 200) begin
            @(negedge clk);
            guard++;
            check(!in_ready, "R2", {22'd0, in_ready}, 23'd0);
            act = pack(out_op, out_dst, out_user, out_src, out_imm, out_up, out_last);
            check(out_valid, "R9", {22'd0, out_valid}, 23'd1);
            if (stalled) check(act == prev, "R11", act, prev);
            check(act == exp_u[idx], exp_t[idx], act, exp_u[idx]);
            prev = act;
            out_ready = ($urandom % 4) != 0;
            stalled = !out_ready;
            if (out_ready) idx++;
        end
        if (guard >= 200) check(1'b0, "R9", 23'(idx), 23'(exp_len));
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready && !out_valid, "R9", {21'd0, in_ready, out_valid}, 23'd2);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog", 23'd0, 23'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid, "R1", {21'd0, in_ready, out_valid}, 23'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R1", {21'd0, in_ready, out_valid}, 23'd2);

        run(16'h0000, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); // R10 copy only
        run(16'h0000, 5'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R10 copy + subtract
        run(16'hFFFF, 5'd13, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1); // R5 max offset 64, R8
        run(16'h8011, 5'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R6 exception return
        run(16'h00F0, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R7 user-forced store
        run(16'h8000, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R7 pc listed: no force
        run(16'h0001, 5'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R4 single register

        for (int n = 0; n < 250; n++) begin
            logic [15:0] l;
            l = 16'($urandom);
            if ($urandom % 8 == 0) l = '0;
            run(l, 5'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), l[15], 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule